// File: doc/BRIEF.md
# Bus Target Command Claim Decoder

This block sits on the target side of a shared parallel bus with multiplexed address and data lines. It watches each address phase and decides whether this target claims the transaction. The decision uses the 4-bit command, the address, a per-slot configuration select line and two programmed windows: one for memory and one for I/O. It reports the address space that was hit, the transfer direction, a normalized command and the full captured address. Logic further down the target then runs the data phases from these outputs.

Memory traffic above the 4 GiB line arrives as two address beats. The first beat carries the low address word with the dual-address command code. The next cycle carries the high word and the real command. When 64-bit support is enabled, the decoder follows that second beat. When it is disabled, the code is handled like a reserved one. Read-line, read-multiple and write-with-invalidate hints are reduced to plain memory read and plain memory write. Configuration accesses are claimed from the select line and the low eleven address bits alone.

Top module: `bus_claim_decoder`

## Requirements
- R1: `is_write_o` reports command bit 0 (1 = write, 0 = read), except for code 1101, which reports 0. `cmd_o` carries the command, except that 1100 and 1110 become 0110 and 1111 becomes 0111.
- R2: Codes 0001 (broadcast event), 0100, 0101, 1000, 1001 and an unfollowed 1101 are never claimed.
- R3: When `INTACK_EN` is set and either window is programmed, code 0000 (interrupt acknowledge) is claimed at any address value. It reports space 4.
- R4: Codes 1010 and 1011 are claimed only when all of these hold: `id_sel` is high, address bits 1:0 are 00, bit `ad[10:8]` of `CFG_FUNC_MASK` is set, and register index `ad[7:2]` is below `CFG_REGS`. Bits 31:11 have no effect. Space is 3.
- R5: Memory codes (0110, 0111, 1100, 1110, 1111) are claimed when address bits 63:2 equal the memory base in every position where the mask is 1. The upper 32 bits are always compared. Bits 1:0 never affect the match but are captured in `addr_o`. Space is 1.
- R6: I/O codes 0010 and 0011 are claimed when all 32 address bits equal `io_base` wherever `io_mask` is 1. They are single-beat only. Space is 2.
- R7: With `dac_en` high, a beat with code 1101 is a low-address beat. The next cycle supplies the address bits 63:32 and the real command. Only memory commands may be claimed after it. With `dac_en` low, 1101 is treated as reserved and no second beat is taken.
- R8: A window whose base (ignoring memory bits 1:0) is all zero is unprogrammed and matches nothing. With both windows unprogrammed, only configuration codes are claimed.
- R9: `claim_o` is high for exactly the one cycle after the final address beat. `space_o`, `cmd_o`, `is_write_o` and `addr_o` change only at a final beat and then hold. An unclaimed final beat sets `space_o` to 0.
- R10: During and after reset, all outputs are zero until the first final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_phase | input | 1 | High on the first address beat of a transaction |
| ad | input | 32 | Address lines |
| cbe | input | 4 | Command lines during address beats |
| id_sel | input | 1 | Configuration select for this slot |
| dac_en | input | 1 | Enables the two-beat 64-bit address form |
| mem_base_lo | input | 32 | Memory window base, bits 31:0 |
| mem_base_hi | input | 32 | Memory window base, bits 63:32 |
| mem_mask | input | 32 | Compare mask for address bits 31:0 (bits 1:0 ignored) |
| io_base | input | 32 | I/O window base |
| io_mask | input | 32 | I/O compare mask |
| claim_o | output | 1 | One-cycle claim pulse |
| space_o | output | 3 | 0 none, 1 memory, 2 I/O, 3 configuration, 4 interrupt acknowledge |
| is_write_o | output | 1 | Direction of the decoded command |
| cmd_o | output | 4 | Normalized command |
| addr_o | output | 64 | Captured address (upper word zero for single beats) |

## Verification
The in-RTL properties check on every cycle that:
- a claim appears only in the cycle after a final beat, and decoded outputs stay stable between final beats;
- reserved and special codes never carry a claim, and no claim happens through a window that was unprogrammed;
- a configuration claim always follows an asserted select;
- any claim with a nonzero upper address word lands in memory space.

Only the bench scenarios can show that the window comparisons pick the exact addresses at their edges, that the hint commands fold into the right normalized codes, that the upper configuration bits are ignored, and that a disabled 64-bit mode leaves the following cycle free for a normal address phase.

// File: rtl/claim_pkg.sv
// Shared command codes and decode categories for the claim decoder.
// Assumes 4-bit commands on the bus command lines.
package claim_pkg;
    localparam logic [3:0] CMD_INTA  = 4'b0000;
    localparam logic [3:0] CMD_DAC   = 4'b1101;
    localparam logic [3:0] CMD_MRD   = 4'b0110;
    localparam logic [3:0] CMD_MWR   = 4'b0111;

    localparam logic [2:0] SP_NONE = 3'd0;
    localparam logic [2:0] SP_MEM  = 3'd1;
    localparam logic [2:0] SP_IO   = 3'd2;
    localparam logic [2:0] SP_CFG  = 3'd3;
    localparam logic [2:0] SP_INTA = 3'd4;

    typedef enum logic [2:0] {
        K_NONE,
        K_INTA,
        K_IO,
        K_MEM,
        K_CFG,
        K_DAC
    } kind_e;
endpackage

// File: rtl/claim_cmd_decode.sv
// Classifies a 4-bit bus command into a category, a normalized code and a
// direction. Purely combinational; assumes the code is valid whenever used.
module claim_cmd_decode
    import claim_pkg::*;
(
    input  logic [3:0] cmd,
    output kind_e      kind,
    output logic [3:0] norm,
    output logic       wr
);
    // Map each code to its category and folded command.
    always_comb begin
        kind = K_NONE;
        norm = cmd;
        wr   = cmd[0];
        case (cmd)
            4'b0000:                   kind = K_INTA;
            4'b0010, 4'b0011:          kind = K_IO;
            4'b0110, 4'b0111:          kind = K_MEM;
            4'b1010, 4'b1011:          kind = K_CFG;
            4'b1100, 4'b1110: begin
                kind = K_MEM;
                norm = CMD_MRD;
            end
            4'b1111: begin
                kind = K_MEM;
                norm = CMD_MWR;
            end
            4'b1101: begin
                kind = K_DAC;
                wr   = 1'b0;
            end
            default:                   kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/claim_addr_match.sv
// Masked equality compare of an address against a window base.
// A mask bit of 1 means that address bit must equal the base bit.
module claim_addr_match #(
    parameter int W = 32
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] base,
    input  logic [W-1:0] mask,
    output logic         hit
);
    logic [W-1:0] bit_ok;

    // One compare cell per address bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_ok[i] = ~mask[i] | (addr[i] ~^ base[i]);
    end

    assign hit = &bit_ok;
endmodule

// File: rtl/claim_cfg_match.sv
// Decides whether a configuration access selects an implemented function
// and register. Assumes type-0 encoding in the low 11 address bits:
// [10:8] function, [7:2] register index, [1:0] must be zero.
module claim_cfg_match #(
    parameter logic [7:0] FUNC_MASK = 8'h01,
    parameter int         REGS      = 16
) (
    input  logic        id_sel,
    input  logic [10:0] low_addr,
    output logic        hit
);
    localparam logic [6:0] REG_LIM = 7'(REGS);

    logic func_ok;
    logic reg_ok;

    // Function implemented and register below the limit.
    always_comb begin
        func_ok = FUNC_MASK[low_addr[10:8]];
        reg_ok  = {1'b0, low_addr[7:2]} < REG_LIM;
        hit     = id_sel && (low_addr[1:0] == 2'b00) && func_ok && reg_ok;
    end
endmodule

// File: rtl/bus_claim_decoder.sv
// Target-side claim decoder. Watches address beats, follows the two-beat
// 64-bit form when enabled, and registers the claim and decoded fields one
// cycle after the final beat. Assumes the bus holds ad/cbe valid on each
// address beat and that the second 64-bit beat follows immediately.
module bus_claim_decoder
    import claim_pkg::*;
#(
    parameter logic [7:0] CFG_FUNC_MASK = 8'h05,
    parameter int         CFG_REGS      = 16,
    parameter bit         INTACK_EN     = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        addr_phase,
    input  logic [31:0] ad,
    input  logic [3:0]  cbe,
    input  logic        id_sel,
    input  logic        dac_en,
    input  logic [31:0] mem_base_lo,
    input  logic [31:0] mem_base_hi,
    input  logic [31:0] mem_mask,
    input  logic [31:0] io_base,
    input  logic [31:0] io_mask,
    output logic        claim_o,
    output logic [2:0]  space_o,
    output logic        is_write_o,
    output logic [3:0]  cmd_o,
    output logic [63:0] addr_o
);
    localparam int AW  = 32;
    localparam int WAW = 2 * AW;
    localparam logic [WAW-1:0] DROP_LOW2 = {{(WAW-2){1'b1}}, 2'b00};

    logic          hi_pend;
    logic [AW-1:0] lo_q;
    logic          first_dac;
    logic          final_beat;
    logic [WAW-1:0] beat_addr;
    kind_e         kind;
    logic [3:0]    norm;
    logic          wr;
    logic          mem_active;
    logic          io_active;
    logic          mem_hit;
    logic          io_hit;
    logic          cfg_hit;
    logic          hit;
    logic [2:0]    space_d;

    claim_cmd_decode u_cmd (
        .cmd  (cbe),
        .kind (kind),
        .norm (norm),
        .wr   (wr)
    );

    claim_addr_match #(.W(WAW)) u_mem (
        .addr (beat_addr),
        .base ({mem_base_hi, mem_base_lo}),
        .mask ({{AW{1'b1}}, mem_mask} & DROP_LOW2),
        .hit  (mem_hit)
    );

    claim_addr_match #(.W(AW)) u_io (
        .addr (ad),
        .base (io_base),
        .mask (io_mask),
        .hit  (io_hit)
    );

    claim_cfg_match #(.FUNC_MASK(CFG_FUNC_MASK), .REGS(CFG_REGS)) u_cfg (
        .id_sel   (id_sel),
        .low_addr (ad[10:0]),
        .hit      (cfg_hit)
    );

    // Beat tracking: which cycle ends an address phase and what address it forms.
    always_comb begin
        first_dac  = addr_phase && !hi_pend && (cbe == CMD_DAC) && dac_en;
        final_beat = hi_pend || (addr_phase && !first_dac);
        beat_addr  = hi_pend ? {ad, lo_q} : {{AW{1'b0}}, ad};
        mem_active = |({mem_base_hi, mem_base_lo} & DROP_LOW2);
        io_active  = |io_base;
    end

    // Claim decision and reported space for the current final beat.
    always_comb begin
        hit     = 1'b0;
        space_d = SP_NONE;
        case (kind)
            K_MEM: begin
                hit     = mem_active && mem_hit;
                space_d = SP_MEM;
            end
            K_IO: begin
                hit     = !hi_pend && io_active && io_hit;
                space_d = SP_IO;
            end
            K_CFG: begin
                hit     = !hi_pend && cfg_hit;
                space_d = SP_CFG;
            end
            K_INTA: begin
                hit     = !hi_pend && INTACK_EN && (mem_active || io_active);
                space_d = SP_INTA;
            end
            default: hit = 1'b0;
        endcase
    end

    // Second-beat pending flag and low address word of the 64-bit form.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_pend <= 1'b0;
            lo_q    <= '0;
        end else begin
            hi_pend <= first_dac;
            if (first_dac) lo_q <= ad;
        end
    end

    // Registered claim pulse and decoded fields, updated per final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            claim_o    <= 1'b0;
            space_o    <= SP_NONE;
            is_write_o <= 1'b0;
            cmd_o      <= '0;
            addr_o     <= '0;
        end else begin
            claim_o <= final_beat && hit;
            if (final_beat) begin
                space_o    <= hit ? space_d : SP_NONE;
                is_write_o <= wr;
                cmd_o      <= norm;
                addr_o     <= beat_addr;
            end
        end
    end

    AST_CLAIM_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |-> $past(final_beat)); // R9
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(final_beat) |-> ($stable(space_o) && $stable(cmd_o) && $stable(addr_o) && $stable(is_write_o))); // R9
    AST_NO_RSVD_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |-> !(cmd_o inside {4'b0001, 4'b0100, 4'b0101, 4'b1000, 4'b1001, 4'b1101})); // R2
    AST_CFG_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_o && space_o == SP_CFG) |-> $past(id_sel)); // R4
    AST_UNPROG_CFG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_o && space_o != SP_CFG) |-> $past(mem_active || io_active)); // R8
    AST_WIDE_IS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_o && addr_o[63:32] != 32'h0) |-> (space_o == SP_MEM)); // R7
endmodule

// File: tb/tb_bus_claim_decoder.sv
module tb_bus_claim_decoder;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] FMASK = 8'h05;
    localparam int NREGS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_phase = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe = '0;
    logic        id_sel = 1'b0;
    logic        dac_en = 1'b0;
    logic [31:0] mem_base_lo = '0, mem_base_hi = '0, mem_mask = '0;
    logic [31:0] io_base = '0, io_mask = '0;
    logic        claim_o;
    logic [2:0]  space_o;
    logic        is_write_o;
    logic [3:0]  cmd_o;
    logic [63:0] addr_o;

    int errors = 0;
    int checks = 0;

    logic       e_claim;
    logic [2:0] e_space;
    logic [3:0] e_cmd;
    logic       e_wr;
    logic [63:0] e_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_claim_decoder #(.CFG_FUNC_MASK(FMASK), .CFG_REGS(NREGS), .INTACK_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .ad(ad), .cbe(cbe),
        .id_sel(id_sel), .dac_en(dac_en), .mem_base_lo(mem_base_lo),
        .mem_base_hi(mem_base_hi), .mem_mask(mem_mask), .io_base(io_base),
        .io_mask(io_mask), .claim_o(claim_o), .space_o(space_o),
        .is_write_o(is_write_o), .cmd_o(cmd_o), .addr_o(addr_o)
    );

    // Expected result from the requirements.
    task automatic model(input bit two, input logic [31:0] hi, input logic [31:0] lo,
                         input logic [3:0] c, input bit ids);
        bit memp, iop, is_mem;
        logic [2:0] sp;
        memp = ({mem_base_hi, mem_base_lo[31:2]} != 0);
        iop  = (io_base != 0);
        e_cmd = (c == 4'b1100 || c == 4'b1110) ? 4'b0110 : (c == 4'b1111) ? 4'b0111 : c; // R1
        e_wr  = (c == 4'b1101) ? 1'b0 : c[0];                                            // R1
        e_addr = {hi, lo};
        is_mem = c inside {4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111};
        e_claim = 1'b0;
        sp = 3'd0;
        if (is_mem) begin // R5
            sp = 3'd1;
            e_claim = memp && (hi == mem_base_hi) &&
                      ((lo[31:2] & mem_mask[31:2]) == (mem_base_lo[31:2] & mem_mask[31:2]));
        end else if (two) begin
            e_claim = 1'b0; // R7
        end else if (c inside {4'b0010, 4'b0011}) begin // R6
            sp = 3'd2;
            e_claim = iop && ((lo & io_mask) == (io_base & io_mask));
        end else if (c inside {4'b1010, 4'b1011}) begin // R4
            sp = 3'd3;
            e_claim = ids && lo[1:0] == 2'b00 && FMASK[lo[10:8]] && (lo[7:2] < NREGS);
        end else if (c == 4'b0000) begin // R3
            sp = 3'd4;
            e_claim = memp || iop;
        end
        e_space = e_claim ? sp : 3'd0;
    endtask

    task automatic check_now(input string req);
        checks++;
        if ({claim_o, space_o, cmd_o, is_write_o, addr_o} !== {e_claim, e_space, e_cmd, e_wr, e_addr}) begin
            errors++;
            $display("FAIL %s: got claim=%0b space=%0d cmd=%b wr=%0b addr=%h exp claim=%0b space=%0d cmd=%b wr=%0b addr=%h",
                     req, claim_o, space_o, cmd_o, is_write_o, addr_o,
                     e_claim, e_space, e_cmd, e_wr, e_addr);
        end
    endtask

    // Next cycle: pulse gone, fields held (R9).
    task automatic check_hold();
        @(negedge clk);
        e_claim = 1'b0;
        check_now("R9 hold");
    endtask

    task automatic single(input logic [31:0] a, input logic [3:0] c, input bit ids, input string req);
        @(negedge clk);
        addr_phase = 1'b1; ad = a; cbe = c; id_sel = ids;
        @(negedge clk);
        addr_phase = 1'b0; ad = 32'hDEAD_BEEF; cbe = 4'b0110; id_sel = 1'b0;
        model(1'b0, 32'h0, a, c, ids);
        check_now(req);
        check_hold();
    endtask

    task automatic wide(input logic [31:0] lo, input logic [31:0] hi, input logic [3:0] c, input string req);
        @(negedge clk);
        addr_phase = 1'b1; ad = lo; cbe = 4'b1101; id_sel = 1'b1;
        @(negedge clk);
        addr_phase = 1'b0; ad = hi; cbe = c;
        @(negedge clk);
        ad = 32'hDEAD_BEEF; cbe = 4'b0110; id_sel = 1'b0;
        model(1'b1, hi, lo, c, 1'b1);
        check_now(req);
        check_hold();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        e_claim = 0; e_space = 0; e_cmd = 0; e_wr = 0; e_addr = 0;
        check_now("R10 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_now("R10 after reset");

        // R8: unprogrammed windows, only configuration claimed.
        for (int c = 0; c < 16; c++) begin
            single(32'h8000_0010, 4'(c), 1'b1, "R8 unprogrammed");
        end

        mem_base_lo = 32'h8000_0000; mem_mask = 32'hFFFF_F000;
        io_base = 32'h0000_0300; io_mask = 32'hFFFF_FFF0;

        // R1 R2 R3 R5 R6: every command over several addresses.
        for (int c = 0; c < 16; c++) begin
            single(32'h8000_0004, 4'(c), 1'b0, "R1 R2 R5 mem inside");
            single(32'h8000_0FFF, 4'(c), 1'b0, "R5 mem top edge, low bits captured");
            single(32'h8000_1000, 4'(c), 1'b0, "R5 mem above");
            single(32'h7FFF_FFFC, 4'(c), 1'b0, "R5 mem below");
            single(32'h0000_030F, 4'(c), 1'b0, "R6 io top");
            single(32'h0000_0310, 4'(c), 1'b0, "R6 io above");
            single(32'h1234_5673, 4'(c), 1'b0, "R3 intack any address");
        end

        // R4: configuration sweep over functions, registers, type bits, upper bits.
        for (int f = 0; f < 8; f++) begin
            for (int r = 14; r < 18; r++) begin
                single({21'h1ABCD, 3'(f), 6'(r), 2'b00}, 4'b1010, 1'b1, "R4 cfg read");
                single({21'h00000, 3'(f), 6'(r), 2'b00}, 4'b1011, 1'b1, "R4 cfg write");
            end
            single({21'h0, 3'(f), 6'd0, 2'b01}, 4'b1010, 1'b1, "R4 type bits");
            single({21'h0, 3'(f), 6'd0, 2'b00}, 4'b1010, 1'b0, "R4 no select");
        end

        // R7: disabled 64-bit mode, 1101 is reserved and the next cycle is a fresh phase.
        single(32'h8000_0010, 4'b1101, 1'b1, "R7 dac disabled");
        @(negedge clk);
        addr_phase = 1'b1; ad = 32'h8000_0020; cbe = 4'b1101;
        @(negedge clk);
        addr_phase = 1'b1; ad = 32'h0000_0304; cbe = 4'b0011;
        @(negedge clk);
        addr_phase = 1'b0;
        model(1'b0, 32'h0, 32'h0000_0304, 4'b0011, 1'b0);
        check_now("R7 no second beat when disabled");
        check_hold();

        // R7: enabled, window above 4 GiB.
        dac_en = 1'b1;
        mem_base_hi = 32'h0000_0001;
        for (int c = 0; c < 16; c++) begin
            wide(32'h8000_0123, 32'h0000_0001, 4'(c), "R7 wide hit per command");
        end
        wide(32'h8000_0123, 32'h0000_0002, 4'b0110, "R7 wide high mismatch");
        wide(32'h8000_2000, 32'h0000_0001, 4'b0111, "R7 wide low mismatch");
        single(32'h8000_0000, 4'b0110, 1'b0, "R5 upper word compared");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule